// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the management-bus master for an Ethernet port. It generates the management clock (MDC) and drives or releases the bidirectional management data line toward one or more PHYs. It can issue frames in either of the two standard station-management formats. The short format uses a 5-bit PHY address and a 5-bit register number. The extended format uses a 5-bit port address, a 5-bit device address and a separate 16-bit register-address cycle.

Software sees four 32-bit registers on a simple write/read port: a configuration/status word, a command word, a data word and an address word. There is no separate "go" bit. A frame starts as a side effect of certain register writes:

- a data write starts a write frame;
- an address write in extended mode starts an address frame;
- a command write with the read flag set starts a read frame.

A busy flag covers each frame. When a read finishes, the captured 16 bits appear in the data word. A missing turnaround response from the PHY sets a read-error flag.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read as zero, MDC is low and the data-line output enable is low. Whenever no frame is in progress, MDC stays low and the output enable stays low.
- R2: The registers sit at byte offsets 0x30 (config/status), 0x34 (command), 0x38 (data) and 0x3C (address).
  - Config/status layout: bit 0 busy and bit 1 read error (both read-only), bit 5 preamble suppress, bit 6 extended-format select, bits 15:7 the 9-bit MDC divider. All other bits read zero.
  - Command layout: bits 4:0 device/register number, bits 9:5 PHY/port address, bit 15 read request. Bit 15 is not stored.
- R3: In short format, a data write sends 32 preamble ones, then start 01, opcode 01, PHY address, register number, turnaround 10 and data bits 15:0. All fields go MSB first, and the master drives every bit. The data word reads back the written value.
- R4: In extended format, an address write sends start 00, opcode 00, port, device, turnaround 10 and the 16-bit address. In short format, an address write only stores the value and starts no frame.
- R5: A command write with bit 15 set sends start and opcode: 01,10 in short format, or 00,11 in extended format. It then sends the command's address fields, releases the line for the 2 turnaround and 16 data bit times, and samples data on MDC rising edges. When busy clears, data bits 15:0 hold the captured value.
- R6: If the line is high when the second turnaround bit is sampled, the read-error flag is set. The next read launch clears it. The flag can only rise while a read frame is in progress.
- R7: With preamble suppress set, a frame has only its 32 frame bits and no preamble.
- R8: One MDC period is 2×div+1 system clocks (low for div+1, high for div). Busy stays set for exactly (frame bits)×(2×div+1) clocks after the launching write.
- R9: A programmed divider below 5 runs MDC as if it were 5. The register still reads back the value that was written.
- R10: While busy is set, writes to any of the four registers are ignored and launch nothing. A write in the last busy cycle is also ignored.
- R11: A command write with bit 15 clear updates the address fields and launches no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data line as seen at the pad |

## Verification
A software write that would launch a frame can land in the very cycle in which the current frame's last MDC period ends and busy drops. The bench derives the exact end cycle from the divider and the frame length. It places a data write on that final busy cycle and expects the write to be dropped: busy stays low and the data word keeps the old value. A write one cycle later must launch normally. A bus-side PHY model captures every driven bit on MDC rising edges and answers reads with a chosen word, either with or without a proper turnaround.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int OFFS_W = 8;
  localparam logic [OFFS_W-1:0] OFS_CFG = 8'h30;
  localparam logic [OFFS_W-1:0] OFS_CMD = 8'h34;
  localparam logic [OFFS_W-1:0] OFS_DAT = 8'h38;
  localparam logic [OFFS_W-1:0] OFS_ADR = 8'h3C;

  localparam int CFG_BUSY    = 0;
  localparam int CFG_ERR     = 1;
  localparam int CFG_NOPRE   = 5;
  localparam int CFG_EXT     = 6;
  localparam int CFG_DIV_LSB = 7;
  localparam int CMD_READ    = 15;

  localparam int FLD_W   = 5;
  localparam int WORD_W  = 16;
  localparam int FRAME_W = 2 + 2 + FLD_W + FLD_W + 2 + WORD_W;

  typedef enum logic [1:0] {FK_WRITE, FK_ADDR, FK_READ} frame_kind_e;

  function automatic logic [FRAME_W-1:0] pack_frame(
      input logic ext, input frame_kind_e kind,
      input logic [FLD_W-1:0] phy, input logic [FLD_W-1:0] dev,
      input logic [WORD_W-1:0] word);
    logic [1:0] st, op, ta;
    st = ext ? 2'b00 : 2'b01;
    ta = 2'b10;
    unique case (kind)
      FK_WRITE: op = 2'b01;
      FK_ADDR:  op = 2'b00;
      default: begin
        op = ext ? 2'b11 : 2'b10;
        ta = 2'b11;
      end
    endcase
    return {st, op, phy, dev, ta, word};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W   = 9,
  parameter int MIN_DIV = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_raw,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] div_eff;
  logic [CNT_W-1:0] cnt_q, cnt_d, half_cnt, last_cnt;
  logic             mdc_d;

  always_comb begin
    div_eff   = (div_raw < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_raw;
    half_cnt  = {1'b0, div_eff};
    last_cnt  = {div_eff, 1'b0};
    rise_tick = run && (cnt_q == half_cnt);
    fall_tick = run && (cnt_q == last_cnt);
    if (!run || fall_tick) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
    mdc_d = run && (cnt_d > half_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc   <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng #(
  parameter int FRAME_W = 32,
  parameter int PRE_W   = 32,
  parameter int WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               pre_en,
  input  logic               is_read,
  input  logic [FRAME_W-1:0] frame,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               busy,
  output logic               rd_frame,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               rd_done,
  output logic               ta_err,
  output logic [WORD_W-1:0]  rd_word
);
  localparam int TOT_W = FRAME_W + PRE_W;
  localparam int CNT_W = $clog2(TOT_W + 1);
  localparam logic [CNT_W-1:0] TA_LATE = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] TA_EARLY = CNT_W'(WORD_W + 2);

  logic [TOT_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d, rd_q, rd_d;
  logic [WORD_W-1:0] cap_q, cap_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    cap_d  = cap_q;
    if (start) begin
      sh_d   = pre_en ? {{PRE_W{1'b1}}, frame} : {frame, {PRE_W{1'b1}}};
      cnt_d  = pre_en ? CNT_W'(TOT_W) : CNT_W'(FRAME_W);
      busy_d = 1'b1;
      rd_d   = is_read;
    end else if (busy_q) begin
      if (rise_tick && rd_q && (cnt_q <= CNT_W'(WORD_W)))
        cap_d = {cap_q[WORD_W-2:0], mdio_i};
      if (fall_tick) begin
        sh_d  = {sh_q[TOT_W-2:0], 1'b1};
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cap_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      cap_q  <= cap_d;
    end
  end

  always_comb begin
    busy     = busy_q;
    rd_frame = busy_q && rd_q;
    rd_done  = busy_q && rd_q && fall_tick && (cnt_q == CNT_W'(1));
    ta_err   = busy_q && rd_q && rise_tick && (cnt_q == TA_LATE) && mdio_i;
    mdio_o   = busy_q ? sh_q[TOT_W-1] : 1'b1;
    mdio_oe  = busy_q && !(rd_q && (cnt_q <= TA_EARLY));
    rd_word  = cap_q;
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 9,
  parameter int MIN_DIV = 5,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFFS_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic              nopre_q, nopre_d, ext_q, ext_d, err_q, err_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [FLD_W-1:0]  phy_q, phy_d, dev_q, dev_d;
  logic [WORD_W-1:0] data_q, data_d, addr_q, addr_d;

  logic eng_busy, rd_frame, rd_done, ta_err, rise_tick, fall_tick;
  logic [WORD_W-1:0] rd_word;

  logic sel_cfg, sel_cmd, sel_dat, sel_adr, idle;
  logic go_wr, go_adr, go_rd, start;
  frame_kind_e       kind;
  logic [FLD_W-1:0]  f_phy, f_dev;
  logic [FRAME_W-1:0] frame;

  always_comb begin
    idle    = !eng_busy;
    sel_cfg = bus_wr && (bus_addr == OFS_CFG) && idle;
    sel_cmd = bus_wr && (bus_addr == OFS_CMD) && idle;
    sel_dat = bus_wr && (bus_addr == OFS_DAT) && idle;
    sel_adr = bus_wr && (bus_addr == OFS_ADR) && idle;
    go_wr   = sel_dat;
    go_adr  = sel_adr && ext_q;
    go_rd   = sel_cmd && bus_wdata[CMD_READ];
    start   = go_wr || go_adr || go_rd;

    kind  = go_rd ? FK_READ : (go_adr ? FK_ADDR : FK_WRITE);
    f_phy = go_rd ? bus_wdata[2*FLD_W-1:FLD_W] : phy_q;
    f_dev = go_rd ? bus_wdata[FLD_W-1:0]       : dev_q;
    frame = pack_frame(ext_q, kind, f_phy, f_dev,
                       go_rd ? {WORD_W{1'b1}} : bus_wdata[WORD_W-1:0]);

    nopre_d = sel_cfg ? bus_wdata[CFG_NOPRE] : nopre_q;
    ext_d   = sel_cfg ? bus_wdata[CFG_EXT]   : ext_q;
    div_d   = sel_cfg ? bus_wdata[CFG_DIV_LSB +: DIV_W] : div_q;
    phy_d   = sel_cmd ? bus_wdata[2*FLD_W-1:FLD_W] : phy_q;
    dev_d   = sel_cmd ? bus_wdata[FLD_W-1:0]       : dev_q;
    addr_d  = sel_adr ? bus_wdata[WORD_W-1:0]      : addr_q;
    if (go_wr)        data_d = bus_wdata[WORD_W-1:0];
    else if (rd_done) data_d = rd_word;
    else              data_d = data_q;
    if (go_rd)        err_d = 1'b0;
    else if (ta_err)  err_d = 1'b1;
    else              err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      nopre_q <= 1'b0;
      ext_q   <= 1'b0;
      err_q   <= 1'b0;
      div_q   <= '0;
      phy_q   <= '0;
      dev_q   <= '0;
      data_q  <= '0;
      addr_q  <= '0;
    end else begin
      nopre_q <= nopre_d;
      ext_q   <= ext_d;
      err_q   <= err_d;
      div_q   <= div_d;
      phy_q   <= phy_d;
      dev_q   <= dev_d;
      data_q  <= data_d;
      addr_q  <= addr_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CFG: begin
        bus_rdata[CFG_BUSY]              = eng_busy;
        bus_rdata[CFG_ERR]               = err_q;
        bus_rdata[CFG_NOPRE]             = nopre_q;
        bus_rdata[CFG_EXT]               = ext_q;
        bus_rdata[CFG_DIV_LSB +: DIV_W]  = div_q;
      end
      OFS_CMD: bus_rdata[2*FLD_W-1:0] = {phy_q, dev_q};
      OFS_DAT: bus_rdata[WORD_W-1:0]  = data_q;
      OFS_ADR: bus_rdata[WORD_W-1:0]  = addr_q;
      default: bus_rdata = '0;
    endcase
  end

  mdio_clkgen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run       (eng_busy),
    .div_raw   (div_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_eng #(.FRAME_W(FRAME_W), .PRE_W(PRE_LEN), .WORD_W(WORD_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .pre_en    (!nopre_q),
    .is_read   (go_rd),
    .frame     (frame),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (eng_busy),
    .rd_frame  (rd_frame),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_done   (rd_done),
    .ta_err    (ta_err),
    .rd_word   (rd_word)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_W  = 9,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rd_frame,
  input logic              mdc,
  input logic              mdio_oe,
  input logic              rd_err,
  input logic [DIV_W-1:0]  div_cfg,
  input logic [WORD_W-1:0] data_word
);
  AST_IDLE_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc)); // R1

  AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(div_cfg)); // R10

  AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(data_word)); // R10

  AST_ERR_RISES_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> (busy && rd_frame)); // R6

  AST_MDC_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy); // R8
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W), .WORD_W(mdio_pkg::WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (eng_busy),
  .rd_frame  (rd_frame),
  .mdc       (mdc),
  .mdio_oe   (mdio_oe),
  .rd_err    (err_q),
  .div_cfg   (div_q),
  .data_word (data_q)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h30;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // PHY model: records driven bits, answers reads
  logic [63:0] cap_o, cap_oe;
  int          nrise, fbits;
  bit          phy_on, ta_bad;
  logic [15:0] resp;

  function automatic logic phy_bit(int idx);
    if (!phy_on || ta_bad) return 1'b1;
    if (idx == fbits - 17) return 1'b0;
    if (idx >= fbits - 16 && idx < fbits) return resp[15 - (idx - (fbits - 16))];
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    cap_o  = {cap_o[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    nrise  = nrise + 1;
    mdio_i = phy_bit(nrise);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic arm(input int nb, input bit on, input bit bad, input logic [15:0] r);
    cap_o = '0; cap_oe = '0; nrise = 0;
    fbits = nb; phy_on = on; ta_bad = bad; resp = r;
    mdio_i = 1'b1;
  endtask

  // called right after a launching wr(); counts busy cycles
  task automatic wait_idle(output int n);
    n = 0;
    bus_addr = 8'h30;
    #1;
    while (bus_rdata[0] && n < 100000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [31:0] mkf(bit ext, int kind, logic [4:0] p, logic [4:0] d, logic [15:0] v);
    logic [1:0] st, op, ta;
    st = ext ? 2'b00 : 2'b01;
    ta = 2'b10;
    if (kind == 0) op = 2'b01;
    else if (kind == 1) op = 2'b00;
    else begin op = ext ? 2'b11 : 2'b10; ta = 2'b11; end
    return {st, op, p, d, ta, v};
  endfunction

  task automatic chk_frame(input string req, input int nb, input logic [63:0] exp, input bit rdf);
    logic [63:0] mask;
    mask = (nb == 64) ? '1 : ((64'd1 << nb) - 1);
    if (!rdf) begin
      chk((cap_o & mask) == exp, req, cap_o & mask, exp);
      chk((cap_oe & mask) == mask, req, cap_oe & mask, mask);
    end else begin
      chk(((cap_o & mask) >> 18) == (exp >> 18), req, (cap_o & mask) >> 18, exp >> 18);
      chk((cap_oe & mask) == (mask & ~64'h3FFFF), req, cap_oe & mask, mask & ~64'h3FFFF);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h30, v); chk(v == 0, "R1 status", v, 0);
    rd(8'h34, v); chk(v == 0, "R1 command", v, 0);
    rd(8'h38, v); chk(v == 0, "R1 data", v, 0);
    rd(8'h3C, v); chk(v == 0, "R1 address", v, 0);
    chk(!mdc && !mdio_oe, "R1 line idle", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_fields;
    logic [31:0] v;
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); chk(v == 32'h0000_FFE0, "R2 status fields", v, 32'hFFE0);
    wr(8'h34, 32'hFFFF_7FFF);
    rd(8'h34, v); chk(v == 32'h0000_03FF, "R2 command fields", v, 32'h3FF);
  endtask

  task automatic t_c22_write;
    logic [31:0] v; int n;
    wr(8'h30, 32'h380);
    wr(8'h34, 32'h26A);
    rd(8'h30, v); chk(v[0] == 1'b0, "R11 no launch on command write", v, 32'h380);
    rd(8'h34, v); chk(v == 32'h26A, "R11 command stored", v, 32'h26A);
    arm(64, 0, 0, 0);
    wr(8'h38, 32'h0000_BEEF);
    wait_idle(n);
    chk(n == 64 * 15, "R8 busy length div7", n, 64 * 15);
    chk_frame("R3 short write frame", 64, {32'hFFFF_FFFF, mkf(0, 0, 5'h13, 5'h0A, 16'hBEEF)}, 0);
    rd(8'h38, v); chk(v == 32'hBEEF, "R3 data readback", v, 32'hBEEF);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v; int n;
    arm(64, 0, 0, 0);
    wr(8'h38, 32'h1234);
    wr(8'h38, 32'h5555);
    wr(8'h34, 32'h8000 | 32'h3FF);
    wr(8'h30, 32'h0);
    wr(8'h3C, 32'h9999);
    wait_idle(n);
    chk_frame("R10 frame unaffected", 64, {32'hFFFF_FFFF, mkf(0, 0, 5'h13, 5'h0A, 16'h1234)}, 0);
    rd(8'h38, v); chk(v == 32'h1234, "R10 data kept", v, 32'h1234);
    rd(8'h34, v); chk(v == 32'h26A, "R10 command kept", v, 32'h26A);
    rd(8'h30, v); chk(v == 32'h380, "R10 status kept", v, 32'h380);
    rd(8'h3C, v); chk(v == 32'h0, "R10 address kept", v, 0);
  endtask

  task automatic t_edge_race;
    logic [31:0] v; int n;
    wr(8'h30, 32'h2A0);
    arm(32, 0, 0, 0);
    wr(8'h38, 32'h0F0F);
    repeat (32 * 11 - 1) @(negedge clk);
    bus_addr = 8'h38; bus_wdata = 32'h7777; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = 8'h30;
    #1 chk(bus_rdata[0] == 1'b0, "R10 last-cycle write no launch", bus_rdata, 0);
    rd(8'h38, v); chk(v == 32'h0F0F, "R10 last-cycle write dropped", v, 32'h0F0F);
    arm(32, 0, 0, 0);
    wr(8'h38, 32'h3333);
    wait_idle(n);
    chk(n == 32 * 11, "R7 R8 busy length no preamble", n, 32 * 11);
    chk_frame("R7 no preamble frame", 32, {32'h0, mkf(0, 0, 5'h13, 5'h0A, 16'h3333)}, 0);
  endtask

  task automatic t_clamp;
    logic [31:0] v; int n;
    wr(8'h30, 32'h120);
    rd(8'h30, v); chk(v == 32'h120, "R9 raw divider readback", v, 32'h120);
    arm(32, 0, 0, 0);
    wr(8'h38, 32'hA001);
    wait_idle(n);
    chk(n == 32 * 11, "R9 clamped period", n, 32 * 11);
  endtask

  task automatic t_ext_addr;
    logic [31:0] v; int n;
    wr(8'h30, 32'h060);
    rd(8'h30, v);
    wr(8'h3C, 32'h1111);
    #1 bus_addr = 8'h30;
    #1 chk(bus_rdata[0] == 1'b1, "R4 address frame launched", bus_rdata, 1);
    wait_idle(n);
    wr(8'h30, 32'h3E0);
    wr(8'h34, 32'h7E);
    arm(32, 0, 0, 0);
    wr(8'h3C, 32'hA5C3);
    wait_idle(n);
    chk(n == 32 * 15, "R4 address busy length", n, 32 * 15);
    chk_frame("R4 extended address frame", 32, {32'h0, mkf(1, 1, 5'h03, 5'h1E, 16'hA5C3)}, 0);
    rd(8'h3C, v); chk(v == 32'hA5C3, "R4 address readback", v, 32'hA5C3);
  endtask

  task automatic t_short_addr;
    logic [31:0] v;
    wr(8'h30, 32'h3A0);
    arm(32, 0, 0, 0);
    wr(8'h3C, 32'h2468);
    bus_addr = 8'h30;
    #1 chk(bus_rdata[0] == 1'b0, "R4 short format address no frame", bus_rdata, 0);
    repeat (40) @(negedge clk);
    chk(nrise == 0, "R4 no MDC activity", nrise, 0);
    rd(8'h3C, v); chk(v == 32'h2468, "R4 address stored", v, 32'h2468);
  endtask

  task automatic t_reads;
    logic [31:0] v; int n;
    wr(8'h30, 32'h3E0);
    arm(32, 1, 0, 16'h5A3C);
    wr(8'h34, 32'h8000 | (32'd7 << 5) | 32'd1);
    wait_idle(n);
    chk_frame("R5 extended read frame", 32, {32'h0, mkf(1, 2, 5'd7, 5'd1, 16'hFFFF)}, 1);
    rd(8'h38, v); chk(v == 32'h5A3C, "R5 extended read data", v, 32'h5A3C);
    rd(8'h30, v); chk(v[1] == 1'b0, "R6 no error on good read", v, 0);
    rd(8'h34, v); chk(v == 32'hE1, "R5 read flag not stored", v, 32'hE1);
    wr(8'h30, 32'h3A0);
    arm(32, 1, 1, 16'h0);
    wr(8'h34, 32'h8000 | (32'd2 << 5) | 32'd9);
    wait_idle(n);
    chk_frame("R5 short read frame", 32, {32'h0, mkf(0, 2, 5'd2, 5'd9, 16'hFFFF)}, 1);
    rd(8'h30, v); chk(v[1] == 1'b1, "R6 error on missing turnaround", v, 2);
    rd(8'h38, v); chk(v == 32'hFFFF, "R6 released line reads ones", v, 32'hFFFF);
    arm(32, 1, 0, 16'h0C35);
    wr(8'h34, 32'h8000 | (32'd2 << 5) | 32'd9);
    #1 bus_addr = 8'h30;
    #1 chk(bus_rdata[1] == 1'b0, "R6 error cleared at launch", bus_rdata, 0);
    wait_idle(n);
    rd(8'h38, v); chk(v == 32'h0C35, "R5 short read data", v, 32'h0C35);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 200000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    arm(32, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_fields;
    t_c22_write;
    t_busy_ignore;
    t_edge_race;
    t_clamp;
    t_ext_addr;
    t_short_addr;
    t_reads;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule